// File: doc/BRIEF.md
# GPIO Interrupt Line Conditioner

The conditioner watches a bank of input lines (32 by default) and folds them into one interrupt request. Every line passes through a two-stage synchroniser. It is then qualified by four per-line controls: an enable, a mask, a trigger-type select (level or edge) and a polarity select. When a line uses edge sensing, the chosen edge is held in a sticky status bit. Software clears that bit by writing a 1 to an end-of-interrupt offset.

Software programs the block over a simple 32-bit register bus with a single-cycle write strobe and combinational read data. Two read-only views are provided. One shows each line's activity before masking and the other shows it after masking. A common use is a plain pass-through: enable and unmask exactly one line, select active-high level sensing for it, and the output follows that input after the synchroniser delay.

Top module: `irq_line_cond`

## Requirements
- R1: After reset, every configuration register, the raw status, the masked status and all latched edges are 0, and `irq_o` is low.
- R2: The enable (0x30), mask (0x34), trigger (0x38) and polarity (0x3C) registers read back the last value written. Writes to the status offsets 0x40 and 0x44 change nothing. Reads of any unmapped offset return 0.
- R3: A change on an input line reaches the raw status (0x40) of an enabled level-sensed line at the second rising clock edge after the change, and not before.
- R4: For a line whose trigger bit is 0 (level), raw status bit i = enable[i] AND (line[i] == polarity[i]). Polarity 1 means active-high and polarity 0 means active-low.
- R5: For a line whose trigger bit is 1 (edge), polarity 1 captures a rising edge and polarity 0 captures a falling edge. The capture appears in raw status at the third rising clock edge after the line changes. It stays set after the line returns to its previous level, and the opposite edge does not set it.
- R6: Writing a word to the end-of-interrupt offset 0x4C clears exactly the latched edge bits that are 1 in that word. All other latched bits and all configuration registers are unchanged. Reads of 0x4C return 0.
- R7: A 1 in mask bit i removes line i from the masked status (0x44) and from `irq_o`. Raw status is not affected.
- R8: While enable bit i is 0, raw status bit i reads 0, edges on line i are not captured, and any edge already latched for line i is discarded. Re-enabling the line does not bring the discarded edge back.
- R9: `irq_o` is the OR of all bits of the masked status, where masked status = raw status AND NOT mask.
- R10: With only line 12 enabled and unmasked, level sensing and polarity 1, `irq_o` follows line 12 two clock edges late. The other lines have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | 32 | Input lines, may be asynchronous to clk |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr while selected for read |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions take it that writes and end-of-interrupt strobes happen only while `bus_sel` is high. They also take it that a new sticky edge bit can come only from a detected edge on an armed line in the previous cycle. They do not constrain when input lines change relative to configuration writes. The bench therefore changes lines only on falling clock edges. It lets each new line pattern settle for several cycles before it reprograms polarity or trigger type, so no edge detection ever coincides with a configuration change. Bus accesses are issued one per cycle, so the bench's arithmetic model of enable, mask, trigger, polarity and sticky edges stays in lock-step with the design.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

  localparam int unsigned BUS_AW = 8;

  localparam logic [BUS_AW-1:0] OFS_LINE_EN   = 8'h30;
  localparam logic [BUS_AW-1:0] OFS_LINE_MASK = 8'h34;
  localparam logic [BUS_AW-1:0] OFS_TRIG_SEL  = 8'h38;
  localparam logic [BUS_AW-1:0] OFS_POL_SEL   = 8'h3C;
  localparam logic [BUS_AW-1:0] OFS_RAW_STAT  = 8'h40;
  localparam logic [BUS_AW-1:0] OFS_MSK_STAT  = 8'h44;
  localparam logic [BUS_AW-1:0] OFS_EOI       = 8'h4C;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_EN,
    REG_MASK,
    REG_TRIG,
    REG_POL,
    REG_RAW,
    REG_MSKD,
    REG_EOI
  } reg_id_e;

  function automatic reg_id_e decode_offset(input logic [BUS_AW-1:0] ofs);
    reg_id_e id;
    case (ofs)
      OFS_LINE_EN:   id = REG_EN;
      OFS_LINE_MASK: id = REG_MASK;
      OFS_TRIG_SEL:  id = REG_TRIG;
      OFS_POL_SEL:   id = REG_POL;
      OFS_RAW_STAT:  id = REG_RAW;
      OFS_MSK_STAT:  id = REG_MSKD;
      OFS_EOI:       id = REG_EOI;
      default:       id = REG_NONE;
    endcase
    return id;
  endfunction

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_edge_bank.sv
module irq_edge_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] trig_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic             clr_stb_i,
  input  logic [WIDTH-1:0] clr_bits_i,
  output logic [WIDTH-1:0] raw_o
);

  // Level match: line equals its polarity bit
  function automatic logic [WIDTH-1:0] level_active(
    input logic [WIDTH-1:0] lvl,
    input logic [WIDTH-1:0] pol
  );
    return ~(lvl ^ pol);
  endfunction

  // Edge in the polarity's direction between two samples
  function automatic logic [WIDTH-1:0] edge_seen(
    input logic [WIDTH-1:0] cur,
    input logic [WIDTH-1:0] prev,
    input logic [WIDTH-1:0] pol
  );
    return (pol & cur & ~prev) | (~pol & ~cur & prev);
  endfunction

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] latch_d;
  logic [WIDTH-1:0] edge_evt;
  logic [WIDTH-1:0] edge_arm;
  logic [WIDTH-1:0] clr_mask;
  logic [WIDTH-1:0] lvl_hit;

  assign edge_evt = edge_seen(level_i, prev_q, pol_i);
  assign edge_arm = en_i & trig_i;
  assign clr_mask = clr_stb_i ? clr_bits_i : '0;
  assign lvl_hit  = level_active(level_i, pol_i);

  // new capture wins over a clear in the same cycle; disabled lines drop state
  assign latch_d = ((latch_q & ~clr_mask) | (edge_evt & edge_arm)) & en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= level_i;
      latch_q <= latch_d;
    end
  end

  assign raw_o = en_i & ((trig_i & latch_q) | (~trig_i & lvl_hit));

  // R5
  edge_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(edge_evt & edge_arm)) == '0));

  // R6
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb_i |=> ((latch_q & $past(clr_bits_i & ~(edge_evt & edge_arm))) == '0));

  // R8
  off_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & ~$past(en_i)) == '0));

endmodule

// File: rtl/irq_cond_regs.sv
module irq_cond_regs
  import irq_cond_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [WIDTH-1:0]  raw_i,
  input  logic [WIDTH-1:0]  masked_i,
  output logic [WIDTH-1:0]  en_o,
  output logic [WIDTH-1:0]  mask_o,
  output logic [WIDTH-1:0]  trig_o,
  output logic [WIDTH-1:0]  pol_o,
  output logic              clr_stb_o,
  output logic [WIDTH-1:0]  clr_bits_o
);

  reg_id_e          sel_id;
  logic             wr_hit;
  logic [WIDTH-1:0] en_q, mask_q, trig_q, pol_q;
  logic [WIDTH-1:0] wr_bits;

  assign sel_id  = bus_sel_i ? decode_offset(bus_addr_i) : REG_NONE;
  assign wr_hit  = bus_sel_i & bus_wr_i;
  assign wr_bits = bus_wdata_i[WIDTH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      trig_q <= '0;
      pol_q  <= '0;
    end else if (wr_hit) begin
      case (sel_id)
        REG_EN:   en_q   <= wr_bits;
        REG_MASK: mask_q <= wr_bits;
        REG_TRIG: trig_q <= wr_bits;
        REG_POL:  pol_q  <= wr_bits;
        default:  ;
      endcase
    end
  end

  assign clr_stb_o  = wr_hit && (sel_id == REG_EOI);
  assign clr_bits_o = wr_bits;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_wr_i) begin
      case (sel_id)
        REG_EN:   bus_rdata_o[WIDTH-1:0] = en_q;
        REG_MASK: bus_rdata_o[WIDTH-1:0] = mask_q;
        REG_TRIG: bus_rdata_o[WIDTH-1:0] = trig_q;
        REG_POL:  bus_rdata_o[WIDTH-1:0] = pol_q;
        REG_RAW:  bus_rdata_o[WIDTH-1:0] = raw_i;
        REG_MSKD: bus_rdata_o[WIDTH-1:0] = masked_i;
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign trig_o = trig_q;
  assign pol_o  = pol_q;

  // R6
  eoi_noside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb_o |=> ($stable(en_q) && $stable(mask_q) && $stable(trig_q) && $stable(pol_q)));

endmodule

// File: rtl/irq_line_cond.sv
module irq_line_cond
  import irq_cond_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq_o
);

  logic [NUM_LINES-1:0] line_sync;
  logic [NUM_LINES-1:0] line_en, line_mask, line_trig, line_pol;
  logic [NUM_LINES-1:0] raw_stat, masked_stat, eoi_bits;
  logic                 eoi_stb;

  irq_sync2 #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (line_i),
    .sync_o  (line_sync)
  );

  irq_edge_bank #(.WIDTH(NUM_LINES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_i    (line_sync),
    .en_i       (line_en),
    .trig_i     (line_trig),
    .pol_i      (line_pol),
    .clr_stb_i  (eoi_stb),
    .clr_bits_i (eoi_bits),
    .raw_o      (raw_stat)
  );

  irq_cond_regs #(.WIDTH(NUM_LINES), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .raw_i       (raw_stat),
    .masked_i    (masked_stat),
    .en_o        (line_en),
    .mask_o      (line_mask),
    .trig_o      (line_trig),
    .pol_o       (line_pol),
    .clr_stb_o   (eoi_stb),
    .clr_bits_o  (eoi_bits)
  );

  assign masked_stat = raw_stat & ~line_mask;
  assign irq_o       = |masked_stat;

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |(line_en & ~line_mask));

endmodule

// File: tb/irq_line_cond_tb.sv
module irq_line_cond_tb_top;
  import irq_cond_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] line_i = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] m_en, m_mask, m_trig, m_pol, m_pins, m_latch;

  always #10 clk = ~clk;

  irq_line_cond dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line_i),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    case (a)
      OFS_LINE_EN:   begin m_en = d; m_latch &= d; end
      OFS_LINE_MASK: m_mask = d;
      OFS_TRIG_SEL:  m_trig = d;
      OFS_POL_SEL:   m_pol = d;
      OFS_EOI:       m_latch &= ~d;
      default: ;
    endcase
  endtask

  task automatic do_reset();
    rst_n = 1'b0; line_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_en = '0; m_mask = '0; m_trig = '0; m_pol = '0; m_pins = '0; m_latch = '0;
  endtask

  task automatic set_pins(input logic [31:0] p);
    logic [31:0] evt;
    evt = (m_pol & p & ~m_pins) | (~m_pol & ~p & m_pins);
    m_latch |= m_en & m_trig & evt;
    m_pins = p;
    line_i = p;
  endtask

  function automatic logic [31:0] exp_raw();
    return m_en & ((m_trig & m_latch) | (~m_trig & ~(m_pins ^ m_pol)));
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    logic [31:0] d;
    logic [31:0] rs;
    do_reset();
    @(negedge clk);

    // R1 reset state
    rd(OFS_LINE_EN, d);   chk("R1 enable", d, 0);
    rd(OFS_LINE_MASK, d); chk("R1 mask", d, 0);
    rd(OFS_TRIG_SEL, d);  chk("R1 trigger", d, 0);
    rd(OFS_POL_SEL, d);   chk("R1 polarity", d, 0);
    rd(OFS_RAW_STAT, d);  chk("R1 raw", d, 0);
    rd(OFS_MSK_STAT, d);  chk("R1 masked", d, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);

    // R2 readback and ignored writes
    wr(OFS_LINE_EN, 32'hA5A5_3C3C);
    wr(OFS_LINE_MASK, 32'h1234_5678);
    wr(OFS_TRIG_SEL, 32'hFFFF_0000);
    wr(OFS_POL_SEL, 32'h0F0F_F0F0);
    rd(OFS_LINE_EN, d);   chk("R2 enable", d, 32'hA5A5_3C3C);
    rd(OFS_LINE_MASK, d); chk("R2 mask", d, 32'h1234_5678);
    rd(OFS_TRIG_SEL, d);  chk("R2 trigger", d, 32'hFFFF_0000);
    rd(OFS_POL_SEL, d);   chk("R2 polarity", d, 32'h0F0F_F0F0);
    wr(OFS_LINE_EN, 0);
    wr(OFS_RAW_STAT, 32'hFFFF_FFFF);
    wr(OFS_MSK_STAT, 32'hFFFF_FFFF);
    rd(OFS_RAW_STAT, d);  chk("R2 raw unwritable", d, 0);
    rd(OFS_MSK_STAT, d);  chk("R2 masked unwritable", d, 0);
    rd(OFS_LINE_MASK, d); chk("R2 mask untouched", d, 32'h1234_5678);
    rd(8'h20, d);         chk("R2 unmapped", d, 0);
    rd(OFS_EOI, d);       chk("R6 eoi reads zero", d, 0);

    // R3 synchroniser latency on a level line
    wr(OFS_LINE_MASK, 0);
    wr(OFS_TRIG_SEL, 0);
    wr(OFS_POL_SEL, 32'h0000_0008);
    wr(OFS_LINE_EN, 32'h0000_0008);
    set_pins(32'h0000_0008);
    @(negedge clk); rd(OFS_RAW_STAT, d); chk("R3 one edge", d, 0);
    @(negedge clk); rd(OFS_RAW_STAT, d); chk("R3 two edges", d, 32'h8);
    chk("R9 irq level", {31'd0, irq_o}, 1);

    // R5 edge capture timing
    set_pins(32'h0000_0048);
    repeat (3) @(negedge clk);
    wr(OFS_TRIG_SEL, 32'h0000_0060);
    wr(OFS_POL_SEL, 32'h0000_0028);
    wr(OFS_LINE_EN, 32'h0000_0068);
    set_pins(32'h0000_0068);
    @(negedge clk);
    @(negedge clk); rd(OFS_RAW_STAT, d); chk("R5 not yet at second edge", d, 32'h8);
    @(negedge clk); rd(OFS_RAW_STAT, d); chk("R5 rising captured", d, 32'h28);
    set_pins(32'h0000_0008);
    repeat (4) @(negedge clk);
    rd(OFS_RAW_STAT, d); chk("R5 sticky and falling", d, 32'h68);

    // R6 end of interrupt
    wr(OFS_EOI, 32'h0000_0020);
    rd(OFS_RAW_STAT, d); chk("R6 selective clear", d, 32'h48);
    rd(OFS_LINE_EN, d);  chk("R6 config intact", d, 32'h68);

    // R7 mask
    wr(OFS_LINE_MASK, 32'h0000_0048);
    rd(OFS_RAW_STAT, d); chk("R7 raw unaffected", d, 32'h48);
    rd(OFS_MSK_STAT, d); chk("R7 masked", d, 0);
    chk("R7 irq masked", {31'd0, irq_o}, 0);
    wr(OFS_LINE_MASK, 32'h0000_0008);
    rd(OFS_MSK_STAT, d); chk("R7 partial mask", d, 32'h40);
    chk("R9 irq from edge", {31'd0, irq_o}, 1);

    // R8 disabled line
    wr(OFS_LINE_EN, 32'h0000_0028);
    rd(OFS_RAW_STAT, d); chk("R8 disabled reads 0", d, 32'h8);
    set_pins(32'h0000_0048); repeat (3) @(negedge clk);
    set_pins(32'h0000_0008); repeat (3) @(negedge clk);
    wr(OFS_LINE_EN, 32'h0000_0068);
    rd(OFS_RAW_STAT, d); chk("R8 latch dropped", d, 32'h8);

    // R4 R5 R9 sweep against arithmetic model
    do_reset();
    rs = 32'h1ACE_B00C;
    for (int k = 0; k < 96; k++) begin
      if (k % 4 == 0) begin
        rs = xs(rs); wr(OFS_LINE_EN, rs | xs(rs ^ 32'h5555_0000));
        rs = xs(rs); wr(OFS_LINE_MASK, rs & xs(rs));
        rs = xs(rs); wr(OFS_TRIG_SEL, rs);
        rs = xs(rs); wr(OFS_POL_SEL, rs);
      end
      if (k % 3 == 2) begin
        rs = xs(rs); wr(OFS_EOI, rs);
      end
      rs = xs(rs);
      set_pins(rs);
      repeat (4) @(negedge clk);
      rd(OFS_RAW_STAT, d); chk("R4/R5 sweep raw", d, exp_raw());
      rd(OFS_MSK_STAT, d); chk("R7 sweep masked", d, exp_raw() & ~m_mask);
      chk("R9 sweep irq", {31'd0, irq_o}, {31'd0, |(exp_raw() & ~m_mask)});
    end

    // R10 single line pass-through
    do_reset();
    wr(OFS_LINE_EN, 32'h0000_1000);
    wr(OFS_LINE_MASK, ~32'h0000_1000);
    wr(OFS_POL_SEL, 32'hFFFF_FFFF);
    for (int j = 0; j < 8; j++) begin
      logic prev_lvl;
      prev_lvl = m_pins[12];
      rs = xs(rs);
      set_pins((rs & ~32'h0000_1000) | {19'd0, j[0], 12'd0});
      @(negedge clk); chk("R10 lag one edge", {31'd0, irq_o}, {31'd0, prev_lvl});
      @(negedge clk); chk("R10 follows line 12", {31'd0, irq_o}, {31'd0, j[0]});
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule